// File: doc/BRIEF.md
# Interval Stall Bottleneck Diagnoser

This block sits beside a processor core and turns raw per-cycle stall events into a compact verdict on what limited the core during the last stretch of work. It counts, per monitored resource, the cycles in which that resource stalled the pipeline, along with the total cycles elapsed. A stretch ends after a fixed number of retired instructions, not after a fixed time. At that point each stall count is judged as a share of the elapsed cycles against a threshold of its own. The result is a six-bit flag vector with a one-cycle valid pulse, which a steering policy elsewhere can read.

Thresholds are kept in a small bank with one set per core type. The input `coreSel` picks which set applies to the interval that is closing. The bank is loaded through a plain write port. To avoid a divider, each threshold is an unsigned Q0.8 fraction. A resource is flagged when `stall * 256 > threshold * cycles`, with both products kept at full width.

Flag bit positions: 0 branch-mispredict stall, 1 L2-miss stall, 2 instruction-cache fetch stall, 3 data-cache load stall, 4 issue-slot exhaustion stall, 5 dispatch blocked by a full window structure.

Top module: `stall_interval_diag`

## Requirements
- R1: While reset is asserted and after its release, until the first interval closes, `bnFlags` is 0 and `bnValid` is 0. Every threshold resets to `DEF_THR`.
- R2: An interval closes in the first cycle in which the retired-instruction total reaches `INTERVAL_LEN` or more. `bnValid` is high for exactly the one cycle that follows that cycle, and at no other time.
- R3: `stallEvt[k]` for k in 0..4 adds one to the stall count of resource k in each cycle it is high. That count drives `bnFlags[k]` and no other flag bit.
- R4: Resource 5 counts a cycle once when any bit of `windowBlk[3:0]` is high, however many of those bits are high in that cycle.
- R5: With threshold T (Q0.8), stall count S and cycle count C of the closed interval, the flag is 1 exactly when S*256 > T*C. Equality does not flag.
- R6: Stalls and the cycle itself in the closing cycle count toward the closing interval. All counters start from zero in the next cycle. Retired instructions beyond `INTERVAL_LEN` in the closing cycle are dropped.
- R7: A write with `thrWrEn` high stores `thrWrData` as the threshold of resource `thrWrRes` (0..5) for core type `thrWrCore`. The close uses the bank selected by `coreSel` in the closing cycle. A write in the closing cycle takes effect only for later intervals.
- R8: Every counter saturates at 2^`CNT_W`-1. When the cycle count of the closed interval is saturated, each flag is 1 exactly when its stall count is nonzero.
- R9: `bnFlags` holds its value in every cycle where `bnValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| retireCnt | input | RET_W | Instructions retired this cycle |
| stallEvt | input | 5 | Stall strobes for resources 0..4 |
| windowBlk | input | 4 | Dispatch-blocked causes: issue queue, reorder buffer, load queue, store queue full |
| coreSel | input | CORE_W | Core type whose threshold set judges a closing interval |
| thrWrEn | input | 1 | Threshold write strobe |
| thrWrCore | input | CORE_W | Core type addressed by the write |
| thrWrRes | input | 3 | Resource addressed by the write (0..5) |
| thrWrData | input | THR_W | Threshold value, Q0.8 |
| bnFlags | output | 6 | Registered bottleneck flags |
| bnValid | output | 1 | One-cycle pulse marking new flags |

## Verification
Two things can fall in the same cycle here: an interval can close while a threshold write lands, and the closing cycle can also carry stall strobes. The bench drives both on purpose. It writes the active core's window threshold in the very cycle that completes the instruction count, and expects the old value to decide that close and the new value to decide the next one. It also raises a lone stall strobe only in the closing cycle against a zero threshold, and expects that flag set in this interval and clear in the following, stall-free one.

// File: rtl/stall_diag_pkg.sv
`timescale 1ns/1ps
package stall_diag_pkg;
  // Number of monitored resources; bit 5 is the window (dispatch-blocked) resource.
  localparam int NUM_RES = 6;
  localparam int RES_W   = 3;
  localparam int WIN_IDX = 5;

  typedef struct packed {
    logic evalNow;  // interval closes this cycle: judge counts
    logic clear;    // interval closes this cycle: restart counters next cycle
  } diagStrobe_t;
endpackage

// File: rtl/diag_ctrl.sv
`timescale 1ns/1ps
module diag_ctrl
  import stall_diag_pkg::*;
#(
  parameter int INTERVAL_LEN = 10000,
  parameter int RET_W        = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RET_W-1:0] retireCnt,
  output diagStrobe_t      strobe
);
  localparam int IC_W = $clog2(INTERVAL_LEN + (1 << RET_W));

  logic [IC_W-1:0] instCnt;
  logic [IC_W-1:0] instSum;
  logic            closeNow;

  always_comb begin
    instSum  = instCnt + IC_W'(retireCnt);
    closeNow = (instSum >= IC_W'(INTERVAL_LEN));
  end

  // Excess retirements in the closing cycle are dropped.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         instCnt <= '0;
    else if (closeNow) instCnt <= '0;
    else               instCnt <= instSum;
  end

  always_comb begin
    strobe.evalNow = closeNow;
    strobe.clear   = closeNow;
  end
endmodule

// File: rtl/diag_thr_bank.sv
`timescale 1ns/1ps
module diag_thr_bank
  import stall_diag_pkg::*;
#(
  parameter int          NUM_CORES = 4,
  parameter int          THR_W     = 8,
  parameter int unsigned DEF_THR   = 64,
  parameter int          CORE_W    = $clog2(NUM_CORES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [CORE_W-1:0]        wrCore,
  input  logic [RES_W-1:0]         wrRes,
  input  logic [THR_W-1:0]         wrData,
  input  logic [CORE_W-1:0]        rdCore,
  output logic [NUM_RES*THR_W-1:0] rdThr
);
  logic [THR_W-1:0] thrReg [NUM_CORES][NUM_RES];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar r = 0; r < NUM_RES; r++) begin : g_res
      logic hitAddr;
      assign hitAddr = wrEn && (wrCore == CORE_W'(c)) && (wrRes == RES_W'(r));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        thrReg[c][r] <= THR_W'(DEF_THR);
        else if (hitAddr) thrReg[c][r] <= wrData;
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_RES; r++) begin
      rdThr[r*THR_W +: THR_W] = thrReg[rdCore][r];
    end
  end
endmodule

// File: rtl/diag_datapath.sv
`timescale 1ns/1ps
module diag_datapath
  import stall_diag_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int THR_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  diagStrobe_t              strobe,
  input  logic [NUM_RES-2:0]       stallEvt,
  input  logic [3:0]               windowBlk,
  input  logic [NUM_RES*THR_W-1:0] thrVec,
  output logic [NUM_RES-1:0]       flags,
  output logic                     flagValid,
  output logic [CNT_W-1:0]         cycleTotal
);
  localparam int               PROD_W = CNT_W + THR_W;
  localparam logic [CNT_W-1:0] CMAX   = '1;

  logic [NUM_RES-1:0] evtVec;
  logic [CNT_W-1:0]   cycCnt;
  logic [CNT_W-1:0]   cycNxt;
  logic               cycSat;
  logic [NUM_RES-1:0] hit;

  // Any of the four full-structure causes counts the cycle once.
  assign evtVec = {(|windowBlk), stallEvt};

  always_comb begin
    cycNxt = (cycCnt == CMAX) ? CMAX : cycCnt + 1'b1;
    cycSat = (cycNxt == CMAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cycCnt <= '0;
    else if (strobe.clear) cycCnt <= '0;
    else                   cycCnt <= cycNxt;
  end

  for (genvar i = 0; i < NUM_RES; i++) begin : g_res
    logic [CNT_W-1:0]  stallCnt;
    logic [CNT_W-1:0]  stallNxt;
    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;

    always_comb begin
      stallNxt = (stallCnt == CMAX) ? CMAX : stallCnt + CNT_W'(evtVec[i]);
      lhs      = {stallNxt, {THR_W{1'b0}}};
      rhs      = PROD_W'(thrVec[i*THR_W +: THR_W]) * PROD_W'(cycNxt);
      hit[i]   = cycSat ? (stallNxt != '0) : (lhs > rhs);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             stallCnt <= '0;
      else if (strobe.clear) stallCnt <= '0;
      else                   stallCnt <= stallNxt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags     <= '0;
      flagValid <= 1'b0;
    end else begin
      flagValid <= strobe.evalNow;
      if (strobe.evalNow) flags <= hit;
    end
  end

  assign cycleTotal = cycCnt;
endmodule

// File: rtl/stall_interval_diag.sv
`timescale 1ns/1ps
module stall_interval_diag
  import stall_diag_pkg::*;
#(
  parameter int          INTERVAL_LEN = 10000,
  parameter int          RET_W        = 3,
  parameter int          CNT_W        = 16,
  parameter int          THR_W        = 8,
  parameter int          NUM_CORES    = 4,
  parameter int unsigned DEF_THR      = 64,
  parameter int          CORE_W       = $clog2(NUM_CORES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RET_W-1:0]   retireCnt,
  input  logic [4:0]         stallEvt,
  input  logic [3:0]         windowBlk,
  input  logic [CORE_W-1:0]  coreSel,
  input  logic               thrWrEn,
  input  logic [CORE_W-1:0]  thrWrCore,
  input  logic [2:0]         thrWrRes,
  input  logic [THR_W-1:0]   thrWrData,
  output logic [5:0]         bnFlags,
  output logic               bnValid
);
  diagStrobe_t              ctrlStrobe;
  logic [NUM_RES*THR_W-1:0] activeThr;
  logic [CNT_W-1:0]         cycleTotal;
  logic                     evalNowW;
  logic                     clearW;

  assign evalNowW = ctrlStrobe.evalNow;
  assign clearW   = ctrlStrobe.clear;

  diag_ctrl #(
    .INTERVAL_LEN(INTERVAL_LEN),
    .RET_W       (RET_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .retireCnt(retireCnt),
    .strobe   (ctrlStrobe)
  );

  diag_thr_bank #(
    .NUM_CORES(NUM_CORES),
    .THR_W    (THR_W),
    .DEF_THR  (DEF_THR),
    .CORE_W   (CORE_W)
  ) u_bank (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (thrWrEn),
    .wrCore(thrWrCore),
    .wrRes (thrWrRes),
    .wrData(thrWrData),
    .rdCore(coreSel),
    .rdThr (activeThr)
  );

  diag_datapath #(
    .CNT_W(CNT_W),
    .THR_W(THR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (ctrlStrobe),
    .stallEvt  (stallEvt),
    .windowBlk (windowBlk),
    .thrVec    (activeThr),
    .flags     (bnFlags),
    .flagValid (bnValid),
    .cycleTotal(cycleTotal)
  );
endmodule

// File: rtl/stall_interval_diag_chk.sv
`timescale 1ns/1ps
module stall_interval_diag_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [5:0]       flags,
  input logic             flagValid,
  input logic             evalNow,
  input logic             clearNow,
  input logic [CNT_W-1:0] cycleTotal
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R2
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |=> !flagValid);

  // R2
  valid_after_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    evalNow |=> flagValid);

  // R2
  valid_needs_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |-> $past(evalNow));

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagValid |-> $stable(flags));

  // R8
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(clearNow)) |->
      (cycleTotal == (($past(cycleTotal) == CMAX) ? CMAX : $past(cycleTotal) + 1'b1)));

  // R6
  cycle_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearNow |=> (cycleTotal == '0));
endmodule

bind stall_interval_diag stall_interval_diag_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .flags     (bnFlags),
  .flagValid (bnValid),
  .evalNow   (evalNowW),
  .clearNow  (clearW),
  .cycleTotal(cycleTotal)
);

// File: tb/stall_interval_diag_bench.sv
`timescale 1ns/1ps
module stall_interval_diag_bench;
  localparam int LEN  = 100;
  localparam int CW   = 9;
  localparam int RW   = 3;
  localparam int NC   = 4;
  localparam int TW   = 8;
  localparam int DEF  = 64;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [RW-1:0] retireCnt = '0;
  logic [4:0]    stallEvt = '0;
  logic [3:0]    windowBlk = '0;
  logic [1:0]    coreSel = '0;
  logic          thrWrEn = 1'b0;
  logic [1:0]    thrWrCore = '0;
  logic [2:0]    thrWrRes = '0;
  logic [TW-1:0] thrWrData = '0;
  logic [5:0]    bnFlags;
  logic          bnValid;

  stall_interval_diag #(
    .INTERVAL_LEN(LEN), .RET_W(RW), .CNT_W(CW), .THR_W(TW),
    .NUM_CORES(NC), .DEF_THR(DEF)
  ) u_stall_interval_diag (
    .clk(clk), .rstN(rstN), .retireCnt(retireCnt), .stallEvt(stallEvt),
    .windowBlk(windowBlk), .coreSel(coreSel), .thrWrEn(thrWrEn),
    .thrWrCore(thrWrCore), .thrWrRes(thrWrRes), .thrWrData(thrWrData),
    .bnFlags(bnFlags), .bnValid(bnValid)
  );

  always #2 clk = ~clk;

  int         errs = 0;
  int         checks = 0;
  int         mThr [NC][6];
  int         mSt [6];
  int         mCyc = 0;
  int         mInst = 0;
  logic [5:0] lastF = '0;
  bit         lastClose = 0;
  string      curReq = "R5";

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic logic expHit(int st, int cyc, int thr);
    if (cyc == CMAX) return st != 0;
    return (st * 256) > (thr * cyc);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < NC; c++) for (int r = 0; r < 6; r++) mThr[c][r] = DEF;
    for (int r = 0; r < 6; r++) mSt[r] = 0;
    mCyc = 0; mInst = 0; lastF = '0;
  endtask

  task automatic tick(int ret, logic [4:0] ev, logic [3:0] win, int core,
                      bit wr = 0, int wc = 0, int wres = 0, int wd = 0);
    logic [5:0] expF;
    bit close;
    expF = '0;
    retireCnt = RW'(ret); stallEvt = ev; windowBlk = win; coreSel = 2'(core);
    thrWrEn = wr; thrWrCore = 2'(wc); thrWrRes = 3'(wres); thrWrData = TW'(wd);
    mCyc = sat(mCyc + 1);
    for (int i = 0; i < 5; i++) if (ev[i]) mSt[i] = sat(mSt[i] + 1);
    if (|win) mSt[5] = sat(mSt[5] + 1);
    mInst += ret;
    close = (mInst >= LEN);
    if (close) begin
      for (int i = 0; i < 6; i++) expF[i] = expHit(mSt[i], mCyc, mThr[core][i]);
      for (int i = 0; i < 6; i++) mSt[i] = 0;
      mCyc = 0; mInst = 0;
    end
    if (wr && wres < 6) mThr[wc][wres] = wd;
    @(posedge clk); #1;
    chk(bnValid == close, "R2", "valid pulse", int'(bnValid), int'(close));
    if (close) begin
      chk(bnFlags == expF, curReq, "flags", int'(bnFlags), int'(expF));
      lastF = expF;
    end else begin
      chk(bnFlags == lastF, "R9", "flags held", int'(bnFlags), int'(lastF));
    end
    lastClose = close;
  endtask

  task automatic flush(int core);
    lastClose = 0;
    while (!lastClose) tick(4, '0, '0, core);
  endtask

  task automatic wrThr(int c, int r, int v, int core);
    tick(0, '0, '0, core, 1, c, r, v);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed_0017);
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs cleared during reset
    chk(bnFlags == 0, "R1", "flags in reset", int'(bnFlags), 0);
    chk(bnValid == 0, "R1", "valid in reset", int'(bnValid), 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk(bnValid == 0 && bnFlags == 0, "R1", "outputs after release",
        int'({bnValid, bnFlags}), 0);
    // R1: default thresholds judge the first interval
    curReq = "R1";
    for (int k = 0; k < 50; k++) tick(2, (k < 20) ? 5'b00001 : 5'b00000, '0, 0);

    // R5: strict compare at the 0.5 boundary (25/50 no flag, 26/50 flag)
    curReq = "R5";
    wrThr(0, 0, 128, 0);
    flush(0);
    for (int k = 0; k < 50; k++) tick(2, (k < 25) ? 5'b00001 : 5'b00000, '0, 0);
    chk(bnFlags[0] == 1'b0, "R5", "equal share not flagged", int'(bnFlags[0]), 0);
    for (int k = 0; k < 50; k++) tick(2, (k < 26) ? 5'b00001 : 5'b00000, '0, 0);
    chk(bnFlags[0] == 1'b1, "R5", "share above flagged", int'(bnFlags[0]), 1);

    // R3: each stall strobe drives only its own flag
    curReq = "R3";
    for (int r = 0; r < 6; r++) wrThr(0, r, 128, 0);
    flush(0);
    for (int i = 0; i < 5; i++) begin
      for (int k = 0; k < 50; k++) tick(2, (k < 30) ? 5'(1 << i) : 5'b00000, '0, 0);
      chk(bnFlags == 6'(1 << i), "R3", "single resource flag", int'(bnFlags), 1 << i);
    end

    // R4: multiple window causes in one cycle count once
    curReq = "R4";
    for (int k = 0; k < 50; k++) tick(2, '0, (k < 20) ? 4'b1111 : 4'b0000, 0);
    chk(bnFlags[5] == 1'b0, "R4", "window counted once", int'(bnFlags[5]), 0);
    for (int k = 0; k < 50; k++) tick(2, '0, (k < 30) ? 4'(1 << (k % 4)) : 4'b0000, 0);
    chk(bnFlags[5] == 1'b1, "R4", "any window cause counts", int'(bnFlags[5]), 1);

    // R6: closing-cycle stall counts; counters restart; excess retirements dropped
    curReq = "R6";
    for (int r = 0; r < 6; r++) wrThr(1, r, 0, 1);
    flush(1);
    for (int k = 0; k < 24; k++) tick(4, '0, '0, 1);
    tick(4, 5'b00010, '0, 1);
    chk(bnFlags == 6'b000010, "R6", "closing stall counted", int'(bnFlags), 2);
    for (int k = 0; k < 25; k++) tick(4, '0, '0, 1);
    chk(bnFlags == 6'b000000, "R6", "counters restarted", int'(bnFlags), 0);
    for (int k = 0; k < 15; k++) tick(7, '0, '0, 1);
    chk(lastClose == 1, "R6", "overshoot close", int'(lastClose), 1);
    for (int k = 0; k < 14; k++) tick(7, '0, '0, 1);
    chk(lastClose == 0, "R6", "excess dropped", int'(lastClose), 0);
    flush(1);

    // R7: per-core banks, and a write in the closing cycle applies later
    curReq = "R7";
    wrThr(2, 5, 255, 2);
    wrThr(3, 5, 0, 3);
    flush(2);
    for (int k = 0; k < 50; k++) tick(2, '0, (k < 5) ? 4'b0010 : 4'b0000, 2);
    chk(bnFlags[5] == 1'b0, "R7", "core 2 bank", int'(bnFlags[5]), 0);
    for (int k = 0; k < 49; k++) tick(2, '0, (k < 5) ? 4'b0010 : 4'b0000, 3);
    tick(2, '0, '0, 3, 1, 3, 5, 255);
    chk(bnFlags[5] == 1'b1, "R7", "write during close uses old", int'(bnFlags[5]), 1);
    for (int k = 0; k < 50; k++) tick(2, '0, (k < 5) ? 4'b0010 : 4'b0000, 3);
    chk(bnFlags[5] == 1'b0, "R7", "new threshold next interval", int'(bnFlags[5]), 0);

    // R8: saturated cycle count flags any nonzero stall count
    curReq = "R8";
    for (int r = 0; r < 6; r++) wrThr(0, r, 255, 0);
    flush(0);
    for (int k = 0; k < 600; k++) tick(0, (k == 10) ? 5'b00100 : 5'b01000, '0, 0);
    for (int k = 0; k < 25; k++) tick(4, '0, '0, 0);
    chk(bnFlags == 6'b001100, "R8", "saturated judgement", int'(bnFlags), 12);

    // Random intervals with random writes and core selection
    curReq = "R5";
    for (int n = 0; n < 40; n++) begin
      int dens;
      dens = int'($urandom % 16);
      lastClose = 0;
      while (!lastClose) begin
        logic [4:0] ev;
        logic [3:0] win;
        bit wr;
        for (int i = 0; i < 5; i++) ev[i] = (($urandom % 16) < dens);
        for (int i = 0; i < 4; i++) win[i] = (($urandom % 32) < dens);
        wr = (($urandom % 20) == 0);
        tick(int'($urandom % 5), ev, win, int'($urandom % 4),
             wr, int'($urandom % 4), int'($urandom % 6), int'($urandom % 256));
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule